// File: doc/BRIEF.md
# Reloadable Register-Programmed Clock Divider

The block divides its input clock by an integer ratio and drives one gated output clock. Software programs it through a small synchronous register port holding two words: a control word and a ratio word. A new ratio is first written into a staging (shadow) field of the ratio word. It does not affect the output until software performs a two-step reload. First it sets a per-clock force request bit in the control word. Then it raises a global reload trigger bit in the same word. Once the output has settled, software clears the request byte and the trigger together, and the divider keeps running at the newly applied ratio.

The ratio that was accepted is handed over to the divider counter only at the end of a full output period. An output enable bit, also in the control word, gates the divided clock. The gate changes state only while the divided clock is low, so the output never shows a shortened pulse. Only the ratios 4, 5, 6 and 8 are accepted.

Top module: `clk_ratio_divider`

## Requirements
- R1: After reset the control word reads 0x00000000, the ratio word reads 0x00000800 (shadow ratio 8 in bits [13:8]), the output is low, and the ratio in use is 8.
- R2: A cycle with wrEn high stores wrData in full into the control word (address 0x0) or the ratio word (address 0x8). rdData returns the addressed word combinationally and returns zero for any other address.
- R3: While enabled, clkOut repeats every N input cycles, where N is the ratio in use. It is high for floor(N/2) cycles and low for the remaining N - floor(N/2) cycles.
- R4: When a control write makes bit 8 (reload trigger) go from 0 to 1 while bit 1 (force request) of the stored control word is 1, the shadow ratio in bits [13:8] of the ratio word is accepted.
- R5: A trigger rising edge with bit 1 clear has no effect on the ratio. Rewriting the control word while bit 8 is already 1 is not a rising edge and has no effect.
- R6: A reload whose shadow ratio is not 4, 5, 6 or 8 leaves the ratio in use unchanged.
- R7: An accepted ratio replaces the one in use only at the end of a complete output period. No high or low phase of clkOut is ever shorter than 2 input cycles.
- R8: Clearing bits [7:0] and bit 8 of the control word together keeps the newly applied ratio.
- R9: Bit 25 of the control word enables the output; while it is clear, clkOut stays low. The enable takes effect, in either direction, only while the divided clock is low.
- R10: Setting or clearing bit 25 by read-modify-write leaves all other control bits as written, and reading the control word returns the current enable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided; also clocks the register port |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register byte address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data for addr |
| clkOut | output | 1 | Gated divided clock |

## Verification
The hardest situation to reach from the ports is a reload strobe that arrives in the middle of an output period. In that case the accepted ratio has to wait for the period boundary while the old ratio keeps running, and a gate change may overlap the same window. The stimulus mixes random legal and illegal shadow values with a random force bit and issues reloads back to back, without waiting for periods to line up. A monitor meanwhile measures every high and low phase for shortened pulses. Directed cases cover a trigger that is held high while a new shadow value is written, and a disable/enable pair issued at arbitrary phases of the output.

// File: rtl/ratio_div_pkg.sv
package ratio_div_pkg;
  localparam int RATIO_W = 6;
  localparam int RATIO_LSB = 8;
  localparam int FORCE_BIT = 1;
  localparam int TRIG_BIT = 8;
  localparam int EN_BIT = 25;
  localparam int CTRL_OFS = 0;
  localparam int RATIO_OFS = 8;
  localparam logic [RATIO_W-1:0] RESET_RATIO = RATIO_W'(8);

  typedef struct packed {
    logic               reloadStb;
    logic [RATIO_W-1:0] newRatio;
    logic               outEnable;
  } dpStrobe_t;

  function automatic logic isLegalRatio(input logic [RATIO_W-1:0] r);
    return (r == RATIO_W'(4)) || (r == RATIO_W'(5)) ||
           (r == RATIO_W'(6)) || (r == RATIO_W'(8));
  endfunction
endpackage

// File: rtl/ratio_div_ctrl.sv
module ratio_div_ctrl
  import ratio_div_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output dpStrobe_t         strobe
);
  localparam logic [DATA_W-1:0] RATIO_RST = DATA_W'(RESET_RATIO) << RATIO_LSB;

  logic [DATA_W-1:0] ctrlWord;
  logic [DATA_W-1:0] ratioWord;
  logic              trigPrev;
  logic [RATIO_W-1:0] shadowRatio;
  logic              trigEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord  <= '0;
      ratioWord <= RATIO_RST;
      trigPrev  <= 1'b0;
    end else begin
      trigPrev <= ctrlWord[TRIG_BIT];
      if (wrEn && addr == ADDR_W'(CTRL_OFS))  ctrlWord  <= wrData;
      if (wrEn && addr == ADDR_W'(RATIO_OFS)) ratioWord <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(CTRL_OFS))  rdData = ctrlWord;
    if (addr == ADDR_W'(RATIO_OFS)) rdData = ratioWord;
  end

  assign shadowRatio = ratioWord[RATIO_LSB +: RATIO_W];
  assign trigEdge    = ctrlWord[TRIG_BIT] && !trigPrev;

  assign strobe.reloadStb = trigEdge && ctrlWord[FORCE_BIT] && isLegalRatio(shadowRatio);
  assign strobe.newRatio  = shadowRatio;
  assign strobe.outEnable = ctrlWord[EN_BIT];
endmodule

// File: rtl/ratio_div_dp.sv
module ratio_div_dp
  import ratio_div_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  output logic               clkOut,
  output logic               divHigh,
  output logic               gateOn,
  output logic [RATIO_W-1:0] cnt,
  output logic [RATIO_W-1:0] curRatio,
  output logic [RATIO_W-1:0] pendRatio
);
  logic periodEnd;

  assign periodEnd = (cnt == curRatio - RATIO_W'(1));
  assign divHigh   = (cnt < (curRatio >> 1));
  assign clkOut    = divHigh && gateOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      curRatio  <= RESET_RATIO;
      pendRatio <= RESET_RATIO;
      gateOn    <= 1'b0;
    end else begin
      if (strobe.reloadStb) pendRatio <= strobe.newRatio;
      if (periodEnd) begin
        cnt      <= '0;
        curRatio <= pendRatio;
      end else begin
        cnt <= cnt + RATIO_W'(1);
      end
      if (!divHigh) gateOn <= strobe.outEnable;
    end
  end
endmodule

// File: rtl/clk_ratio_divider.sv
module clk_ratio_divider
  import ratio_div_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              clkOut
);
  dpStrobe_t          strobe;
  logic               divHigh;
  logic               gateOn;
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] curRatio;
  logic [RATIO_W-1:0] pendRatio;

  ratio_div_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .strobe(strobe)
  );

  ratio_div_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .clkOut(clkOut),
    .divHigh(divHigh), .gateOn(gateOn), .cnt(cnt),
    .curRatio(curRatio), .pendRatio(pendRatio)
  );
endmodule

// File: rtl/ratio_div_chk.sv
module ratio_div_chk
  import ratio_div_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               reloadStb,
  input logic               divHigh,
  input logic               gateOn,
  input logic [RATIO_W-1:0] cnt,
  input logic [RATIO_W-1:0] curRatio,
  input logic [RATIO_W-1:0] pendRatio
);
  // R3
  cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt < curRatio);

  // R6
  legal_ratio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curRatio == RATIO_W'(4)) || (curRatio == RATIO_W'(5)) ||
    (curRatio == RATIO_W'(6)) || (curRatio == RATIO_W'(8)));

  // R4
  pend_only_on_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendRatio != $past(pendRatio)) |-> $past(reloadStb));

  // R7
  ratio_swap_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curRatio != $past(curRatio)) |-> (cnt == '0));

  // R9
  gate_moves_when_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(divHigh) |-> (gateOn == $past(gateOn)));
endmodule

bind clk_ratio_divider ratio_div_chk u_chk (
  .clk(clk), .rstN(rstN), .reloadStb(strobe.reloadStb), .divHigh(divHigh),
  .gateOn(gateOn), .cnt(cnt), .curRatio(curRatio), .pendRatio(pendRatio)
);

// File: tb/test_clk_ratio_divider.sv
module test_clk_ratio_divider;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EN = 32'h1 << 25;
  localparam logic [31:0] FORCE = 32'h2;
  localparam logic [31:0] TRIG = 32'h100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        clkOut;

  int nChecks = 0;
  int nFails = 0;
  int runts = 0;
  int expRatio = 8;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_ratio_divider i_clk_ratio_divider (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .clkOut(clkOut)
  );

  function automatic bit legal(input int r);
    return r == 4 || r == 5 || r == 6 || r == 8;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdData;
  endtask

  task automatic measure(output int per, output int hi);
    per = 0; hi = 0;
    while (clkOut) @(negedge clk);
    while (!clkOut) @(negedge clk);
    while (clkOut) begin hi++; per++; @(negedge clk); end
    while (!clkOut) begin per++; @(negedge clk); end
  endtask

  task automatic checkRate(input string req);
    int per, hi;
    measure(per, hi); measure(per, hi); measure(per, hi);
    check(per == expRatio, req, per, expRatio);
    check(hi == expRatio / 2, req, hi, expRatio / 2);
  endtask

  task automatic reload(input int shadow, input bit force_);
    logic [31:0] base;
    base = EN | (force_ ? FORCE : 32'h0);
    wr(4'h8, 32'(shadow) << 8);
    wr(4'h0, base);
    wr(4'h0, base | TRIG);
    repeat (3) @(negedge clk);
    wr(4'h0, EN);
    if (force_ && legal(shadow)) expRatio = shadow;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  // runt monitor for R7 / R9
  int hiRun = 0, loRun = 0;
  bit seenHigh = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (clkOut) begin
        if (!seenHigh || loRun > 0) begin
          if (seenHigh && loRun < 2) runts++;
          loRun = 0; hiRun = 0;
        end
        seenHigh = 1; hiRun++;
      end else begin
        if (hiRun > 0) begin
          if (hiRun < 2) runts++;
          hiRun = 0;
        end
        loRun++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    logic [31:0] d, v;
    int per, hi;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(4'h0, d); check(d == 32'h0, "R1 ctrl", d, 0);
    rd(4'h8, d); check(d == 32'h800, "R1 ratio", d, 32'h800);
    repeat (20) begin @(negedge clk); check(!clkOut, "R1 out low", clkOut, 0); end

    // R2 unmapped address, R9 enable, R3 default ratio 8
    rd(4'h4, d); check(d == 32'h0, "R2 unmapped", d, 0);
    wr(4'h0, EN);
    rd(4'h0, d); check(d == EN, "R2 ctrl readback", d, EN);
    checkRate("R3 ratio 8");

    // R5 trigger without force
    reload(5, 0);
    checkRate("R5 no force");

    // R4 reload applies, R8 clearing keeps it
    reload(5, 1);
    checkRate("R4 ratio 5");
    repeat (30) @(negedge clk);
    checkRate("R8 kept after clear");

    // R6 illegal value
    reload(7, 1);
    checkRate("R6 illegal 7");
    reload(0, 1);
    checkRate("R6 illegal 0");

    // R5 trigger held high: no new edge
    reload(6, 1);
    wr(4'h0, EN | FORCE | TRIG);
    repeat (3) @(negedge clk);
    wr(4'h8, 32'h400);
    wr(4'h0, EN | FORCE | TRIG);
    repeat (3) @(negedge clk);
    checkRate("R5 held trigger");
    wr(4'h0, EN);
    rd(4'h8, d); check(d == 32'h400, "R2 ratio readback", d, 32'h400);

    // R10 read-modify-write of enable
    v = ($urandom() & ~32'h1FF) | EN;
    wr(4'h0, v);
    rd(4'h0, d); check(d == v, "R10 set readback", d, v);
    wr(4'h0, d & ~EN);
    rd(4'h0, d); check(d == (v & ~EN), "R10 clear readback", d, v & ~EN);
    check(d[25] == 1'b0, "R10 enable state", d[25], 0);

    // R9 disabled output stays low
    repeat (2 * 8) @(negedge clk);
    hi = 0;
    repeat (40) begin @(negedge clk); if (clkOut) hi++; end
    check(hi == 0, "R9 disabled low", hi, 0);
    wr(4'h0, EN);
    checkRate("R9 re-enabled");

    // random reloads, mixed with enable toggles at arbitrary phase
    for (int i = 0; i < 24; i++) begin
      int sh;
      bit f;
      case ($urandom() % 7)
        0: sh = 3; 1: sh = 4; 2: sh = 5; 3: sh = 6;
        4: sh = 7; 5: sh = 8; default: sh = 0;
      endcase
      f = 1'($urandom() % 2);
      if ($urandom() % 3 == 0) begin
        repeat ($urandom() % 5) @(negedge clk);
        wr(4'h0, 32'h0);
        repeat ($urandom() % 7) @(negedge clk);
        wr(4'h0, EN);
      end
      reload(sh, f);
      if (i % 3 == 0) checkRate("R4 random reload");
    end
    checkRate("R6 random final");

    // R7 no shortened phase anywhere
    check(runts == 0, "R7 runt pulses", runts, 0);

    done = 1;
    summary();
  end
endmodule